// File: doc/BRIEF.md
# Clock Alarm Transition Cause Register

This block watches four status levels from a clock synchronizer: primary reference lost, secondary reference lost, PLL holdover and PLL unlock. Each level passes through a two-flop synchronizer. The current synchronized levels appear in the upper nibble of a readable status byte. The lower nibble of that byte is a small set of writable output-enable controls.

Every low-to-high and high-to-low transition of each level sets its own sticky bit in an eight-bit cause byte. A host reads the cause byte to learn what changed, and that read clears the whole byte in one step. A dedicated level interrupt line stays high while any cause bit is set. A host throws away stale events with one read of the cause byte, for example before it enables the interrupt.

Two fixed read-only bytes complete the port. One is a version number. The other carries an interrupt routing number in its low nibble, where the value 0xF means the function is absent.

Top module: `alarm_edge_irq`

## Requirements
- R1: Register address 0 reads the status byte. Bit 7 is primary-lost (`alarm_in[0]`), bit 6 is secondary-lost (`alarm_in[1]`), bit 5 is holdover (`alarm_in[2]`) and bit 4 is unlock (`alarm_in[3]`), each taken after the synchronizer. Bits 3:0 read back the control nibble.
- R2: A rising transition of `alarm_in[i]` sets cause bit 2*i and leaves the other bits unchanged. Cause bits stay set until a clearing read.
- R3: A falling transition of `alarm_in[i]` sets cause bit 2*i+1.
- R4: A read at address 1 returns the latched cause byte and clears all of its bits at that clock edge.
- R5: A transition that reaches the cause logic in the same cycle as a clearing read is latched after the clear. The read itself returns the byte as it was before that transition.
- R6: `irq` is high whenever any cause bit is set. It goes low in the cycle after a clearing read when no new transition arrives.
- R7: Reset clears the cause byte and loads the synchronizer and previous-level registers from the present inputs. Inputs that are already high during reset therefore report no transition.
- R8: Address 2 reads the parameter `VERSION_ID`. Address 3 reads `ROUTE_ID` in bits 3:0 and zero in bits 7:4. Writes to either address have no effect.
- R9: A write to address 0 loads `wdata[3:0]` into the control nibble, which drives `out_en`. The status bits are not writable.
- R10: `rdata` is zero when `rd` is low. A write to address 1 neither clears nor sets cause bits.
- R11: An input change made before clock edge k shows up in the cause byte and on `irq` after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_in | input | 4 | Raw alarm levels: 0 primary-lost, 1 secondary-lost, 2 holdover, 3 unlock |
| addr | input | 2 | Register select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt, high while any cause bit is set |
| out_en | output | 4 | Control nibble of the status byte |

## Verification
The assertions assume that `rd` and `wr` are never high together. They also assume that `alarm_in` changes only between clock edges, so each change reaches the edge logic as one clean step. The stimulus changes `alarm_in` and the strobes only on falling clock edges. Each strobe is held for exactly one cycle, and no alarm input changes again until the previous change has been latched. The single overlap case is built on purpose so that a transition meets a clearing read in the same cycle.

// File: rtl/alarm_cause_pkg.sv
package alarm_cause_pkg;
    localparam int NUM_ALARMS = 4;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int CAUSE_W    = 2 * NUM_ALARMS;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS  = 2'd0,
        REG_CAUSE   = 2'd1,
        REG_VERSION = 2'd2,
        REG_ROUTE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_ALARMS-1:0] fall;
        logic [NUM_ALARMS-1:0] rise;
    } edge_set_t;

    // Interleave edges: bit 2i rising, bit 2i+1 falling
    function automatic logic [CAUSE_W-1:0] pack_cause(input edge_set_t e);
        logic [CAUSE_W-1:0] c;
        for (int i = 0; i < NUM_ALARMS; i++) begin
            c[2*i]   = e.rise[i];
            c[2*i+1] = e.fall[i];
        end
        return c;
    endfunction

    // Alarm 0 lands on the top status bit, alarm 3 on the lowest of the nibble
    function automatic logic [NUM_ALARMS-1:0] status_nibble(input logic [NUM_ALARMS-1:0] lvl);
        logic [NUM_ALARMS-1:0] s;
        for (int i = 0; i < NUM_ALARMS; i++) begin
            s[NUM_ALARMS-1-i] = lvl[i];
        end
        return s;
    endfunction
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[g] <= raw[g];
                sync_q[g] <= raw[g];
                prev_q[g] <= raw[g];
            end else begin
                meta_q[g] <= raw[g];
                sync_q[g] <= meta_q[g];
                prev_q[g] <= sync_q[g];
            end
        end
        assign rise[g] =  sync_q[g] & ~prev_q[g];
        assign fall[g] = ~sync_q[g] &  prev_q[g];
    end

    assign level = sync_q;
endmodule

// File: rtl/cause_reg.sv
module cause_reg
    import alarm_cause_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CAUSE_W-1:0] evt,
    input  logic               clr,
    output logic [CAUSE_W-1:0] cause
);
    logic [CAUSE_W-1:0] kept;

    always_comb begin
        kept = clr ? '0 : cause;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause <= '0;
        end else begin
            cause <= kept | evt;
        end
    end
endmodule

// File: rtl/host_regs.sv
module host_regs
    import alarm_cause_pkg::*;
#(
    parameter logic [DATA_W-1:0] VERSION_ID = 8'h21,
    parameter logic [3:0]        ROUTE_ID   = 4'h5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_ALARMS-1:0] lvl,
    input  logic [CAUSE_W-1:0]    cause,
    output logic [DATA_W-1:0]     rdata,
    output logic [3:0]            ctrl,
    output logic                  clr
);
    reg_sel_e sel;

    always_comb begin
        sel = reg_sel_e'(addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr && sel == REG_STATUS) begin
            ctrl <= wdata[3:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (sel)
                REG_STATUS:  rdata = {status_nibble(lvl), ctrl};
                REG_CAUSE:   rdata = cause;
                REG_VERSION: rdata = VERSION_ID;
                REG_ROUTE:   rdata = {4'h0, ROUTE_ID};
                default:     rdata = '0;
            endcase
        end
    end

    assign clr = rd && (sel == REG_CAUSE);
endmodule

// File: rtl/alarm_edge_irq.sv
module alarm_edge_irq
    import alarm_cause_pkg::*;
#(
    parameter logic [7:0] VERSION_ID = 8'h21,
    parameter logic [3:0] ROUTE_ID   = 4'h5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] alarm_in,
    input  logic [1:0] addr,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic [3:0] out_en
);
    logic [NUM_ALARMS-1:0] lvl;
    edge_set_t             edges;
    logic [CAUSE_W-1:0]    evt_byte;
    logic [CAUSE_W-1:0]    cause_q;
    logic                  clr_pulse;

    alarm_sync #(.N(NUM_ALARMS)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (alarm_in),
        .level (lvl),
        .rise  (edges.rise),
        .fall  (edges.fall)
    );

    assign evt_byte = pack_cause(edges);

    cause_reg u_cause (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_byte),
        .clr   (clr_pulse),
        .cause (cause_q)
    );

    host_regs #(.VERSION_ID(VERSION_ID), .ROUTE_ID(ROUTE_ID)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .rd    (rd),
        .wr    (wr),
        .addr  (addr),
        .wdata (wdata),
        .lvl   (lvl),
        .cause (cause_q),
        .rdata (rdata),
        .ctrl  (out_en),
        .clr   (clr_pulse)
    );

    assign irq = |cause_q;
endmodule

// File: rtl/alarm_edge_irq_checker.sv
module alarm_edge_irq_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] addr,
    input logic       rd,
    input logic       wr,
    input logic [7:0] rdata,
    input logic       irq,
    input logic [3:0] out_en,
    input logic [7:0] cause_q,
    input logic [7:0] evt_byte
);
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(rd && addr == 2'd1) |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(evt_byte)) == 8'h00)); // R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == 2'd1) |=> ((cause_q & ~$past(evt_byte)) == 8'h00)); // R4

    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (evt_byte != 8'h00) |=> ((cause_q & $past(evt_byte)) == $past(evt_byte))); // R5

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == 2'd1 && evt_byte == 8'h00) |=> !irq); // R6

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == 2'd0) |=> $stable(out_en)); // R9

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (rdata == 8'h00)); // R10
endmodule

bind alarm_edge_irq alarm_edge_irq_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .rd       (rd),
    .wr       (wr),
    .rdata    (rdata),
    .irq      (irq),
    .out_en   (out_en),
    .cause_q  (cause_q),
    .evt_byte (evt_byte)
);

// File: tb/alarm_edge_irq_tb.sv
module alarm_edge_irq_tb;
    localparam logic [7:0] VER = 8'h21;
    localparam logic [3:0] RTE = 4'h5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] alarm_in = 4'b1010;
    logic [1:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic [3:0] out_en;

    int total = 0;
    int bad = 0;
    logic [3:0] ctrl_m = 4'h0;

    always #4 clk = ~clk;

    alarm_edge_irq #(.VERSION_ID(VER), .ROUTE_ID(RTE)) u_dut (
        .clk(clk), .rst(rst), .alarm_in(alarm_in), .addr(addr), .rd(rd),
        .wr(wr), .wdata(wdata), .rdata(rdata), .irq(irq), .out_en(out_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic [3:0] lvl, input logic [3:0] c);
        return {lvl[0], lvl[1], lvl[2], lvl[3], c};
    endfunction

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic set_alarm(input logic [3:0] v);
        @(negedge clk);
        alarm_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R7 irq after reset", {7'h0, irq}, 8'h00);
        host_read(2'd1, d);
        check("R7 cause after reset", d, 8'h00);
        host_read(2'd0, d);
        check("R1 status after reset", d, exp_status(alarm_in, ctrl_m));
    endtask

    task automatic t_rise();
        logic [7:0] d;
        set_alarm(4'b1011);
        check("R6 irq set", {7'h0, irq}, 8'h01);
        host_read(2'd1, d);
        check("R2 primary rise", d, 8'h01);
        check("R6 irq drop", {7'h0, irq}, 8'h00);
        host_read(2'd1, d);
        check("R4 cleared", d, 8'h00);
        host_read(2'd0, d);
        check("R1 status", d, exp_status(4'b1011, ctrl_m));
    endtask

    task automatic t_fall();
        logic [7:0] d;
        set_alarm(4'b1001);
        host_read(2'd1, d);
        check("R3 secondary fall", d, 8'h08);
    endtask

    task automatic t_multi();
        logic [7:0] d;
        set_alarm(4'b0101);
        host_read(2'd1, d);
        check("R2 R3 holdover rise unlock fall", d, 8'h90);
        host_read(2'd0, d);
        check("R1 status holdover", d, exp_status(4'b0101, ctrl_m));
    endtask

    task automatic t_latency();
        logic [7:0] d;
        @(negedge clk);
        alarm_in = 4'b0111;
        repeat (2) @(posedge clk);
        #1 check("R11 not before third edge", {7'h0, irq}, 8'h00);
        @(posedge clk);
        #1 check("R11 after third edge", {7'h0, irq}, 8'h01);
        host_read(2'd1, d);
        check("R11 secondary rise", d, 8'h04);
    endtask

    task automatic t_overlap();
        logic [7:0] d;
        @(negedge clk);
        alarm_in = 4'b0110;
        repeat (2) @(posedge clk);
        host_read(2'd1, d);
        check("R5 read before event", d, 8'h00);
        check("R5 irq kept", {7'h0, irq}, 8'h01);
        host_read(2'd1, d);
        check("R5 event survives clear", d, 8'h02);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        host_write(2'd2, 8'hFF);
        host_write(2'd3, 8'hFF);
        host_read(2'd2, d);
        check("R8 version", d, VER);
        host_read(2'd3, d);
        check("R8 route", d, {4'h0, RTE});
        host_write(2'd0, 8'hFA);
        ctrl_m = 4'hA;
        check("R9 out_en", {4'h0, out_en}, 8'h0A);
        host_read(2'd0, d);
        check("R9 status upper nibble not written", d, exp_status(4'b0110, ctrl_m));
    endtask

    task automatic t_idle();
        logic [7:0] d;
        set_alarm(4'b1110);
        host_write(2'd1, 8'h00);
        host_write(2'd1, 8'hFF);
        @(negedge clk);
        addr = 2'd1;
        #1 check("R10 rdata idle", rdata, 8'h00);
        host_read(2'd1, d);
        check("R10 write to cause ignored", d, 8'h40);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_multi();
        t_latency();
        t_overlap();
        t_regs();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule